// File: doc/BRIEF.md
# Slave Receive Acknowledge Controller

This block chooses the level an I2C slave puts on the data line during the acknowledge slot that follows each received byte. Software asks for a not-acknowledge by writing a one into a sticky request flag through a register write port. A separate bit-level engine reports bus events as one-cycle strobes: the not-acknowledge has gone out, a STOP was seen, the own address matched, a receive overrun happened. Each of these except overrun clears the request, and so does dropping the peripheral enable.

Two conditions take over from the software flag. An overrun while clock stretching is disabled forces a not-acknowledge. A packet-error-check byte, while hardware checking is on, is acknowledged when the check passes and refused when it fails. In master mode the flag is ignored and received bytes are acknowledged. The decision is captured in a register on the cycle that opens each acknowledge slot. It then holds for the whole slot.

Top module: `slave_ack_ctrl`

## Requirements
- R1: A register write with bit 15 (parameter FLAG_BIT) of the write data at 1 sets the request flag one cycle later. The readback `nack_req_q` then reads 1.
- R2: A register write with that bit at 0 leaves the request flag unchanged.
- R3: A `nack_sent`, `stop_det` or `addr_match` strobe clears the flag one cycle later. This holds even when a setting write arrives in the same cycle.
- R4: While `periph_en` is low the flag reads 0 and writes do not set it.
- R5: At a slot start in slave mode, with no override active, `nack_out` takes the flag value one cycle later. Level 0 means ACK and 1 means NACK.
- R6: In slave mode with `no_stretch` high, an overrun forces `nack_out` to 1 at the next slot start. The flag value does not matter, and the overrun may come in the same cycle as the slot start or any earlier cycle. A slot start or STOP consumes the pending overrun.
- R7: When `pec_chk_en` and `byte_is_pec` are both high at a slot start, `nack_out` becomes the inverse of `pec_ok` and the flag is ignored. An R6 overrun still wins.
- R8: In master mode (`slave_mode` low), a slot start gives `nack_out` = 0 whatever the flag, unless R7 applies.
- R9: `nack_out` changes only on the cycle after a slot start, or after `periph_en` low, which resets it to 0.
- R10: After reset `nack_out` and `nack_req_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable |
| slave_mode | input | 1 | 1 = addressed as slave, 0 = master |
| no_stretch | input | 1 | Clock stretching disabled |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| nack_sent | input | 1 | Strobe: a NACK went out on the bus |
| stop_det | input | 1 | Strobe: STOP condition detected |
| addr_match | input | 1 | Strobe: own address matched |
| rx_overrun | input | 1 | Strobe: receive overrun |
| pec_chk_en | input | 1 | Hardware error-check byte checking on |
| byte_is_pec | input | 1 | Current byte is the error-check byte |
| pec_ok | input | 1 | Error-check comparison passed |
| slot_start | input | 1 | Strobe: acknowledge slot begins |
| nack_out | output | 1 | Acknowledge level held for the slot (1 = NACK) |
| nack_req_q | output | 1 | Readback of the request flag |

## Verification
Each strobe or write is registered once, so flag and slot results are due exactly one clock after the cycle that carries the stimulus. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It also checks that the result has not moved before the next slot start. Same-cycle collisions are handled the same way: set against clear, and overrun against slot start.

// File: rtl/ack_pkg.sv
// Package: shared types for the slave acknowledge controller.
// Assumes: active-high NACK encoding (1 = release SDA = NACK).
package ack_pkg;
    typedef enum logic [1:0] {
        SRC_FLAG   = 2'd0,
        SRC_MASTER = 2'd1,
        SRC_PEC    = 2'd2,
        SRC_OVR    = 2'd3
    } ack_src_e;

    typedef struct packed {
        ack_src_e src;
        logic     nack;
    } ack_dec_t;
endpackage

// File: rtl/nack_req_flag.sv
// Module: sticky software NACK request flag.
// Does: sets on a register write whose FLAG_BIT is 1, clears on bus events
// or while the peripheral is disabled. Clear beats set in the same cycle.
// Assumes: event strobes are one cycle wide and synchronous to clk.
module nack_req_flag #(
    parameter int REG_W    = 16,
    parameter int FLAG_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             nack_sent,
    input  logic             stop_det,
    input  logic             addr_match,
    output logic             flag_q
);
    logic clr_evt;
    logic set_req;

    // Combine the hardware clear sources.
    always_comb clr_evt = nack_sent | stop_det | addr_match;

    // Only a written one requests a set.
    always_comb set_req = reg_wr & reg_wdata[FLAG_BIT];

    // Flag register: disable and events clear, software only sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (!periph_en || clr_evt)
            flag_q <= 1'b0;
        else if (set_req)
            flag_q <= 1'b1;
    end
endmodule

// File: rtl/ovr_pending.sv
// Module: remembers an overrun that must force NACK at the next slot.
// Does: captures an overrun seen in slave mode without clock stretching;
// consumed by a slot start, dropped on STOP or disable.
// Assumes: slot_start and rx_overrun are one-cycle strobes.
module ovr_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic periph_en,
    input  logic slave_mode,
    input  logic no_stretch,
    input  logic rx_overrun,
    input  logic slot_start,
    input  logic stop_det,
    output logic force_now
);
    logic pend_q;
    logic arm;

    // An overrun counts only in slave mode with stretching off.
    always_comb arm = rx_overrun & slave_mode & no_stretch;

    // Force seen by this slot: stored or arriving now, still qualified.
    always_comb force_now = (pend_q | arm) & slave_mode & no_stretch;

    // Pending register: slot start consumes, STOP and disable drop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (!periph_en || slot_start || stop_det)
            pend_q <= 1'b0;
        else if (arm)
            pend_q <= 1'b1;
    end
endmodule

// File: rtl/ack_select.sv
// Module: combinational acknowledge decision.
// Does: priority overrun > error-check byte > master mode > software flag.
// Assumes: inputs are stable during the slot start cycle.
module ack_select
    import ack_pkg::*;
(
    input  logic     force_ovr,
    input  logic     pec_chk_en,
    input  logic     byte_is_pec,
    input  logic     pec_ok,
    input  logic     slave_mode,
    input  logic     flag_q,
    output ack_dec_t dec
);
    // Pick the source and level in priority order.
    always_comb begin
        if (force_ovr) begin
            dec.src  = SRC_OVR;
            dec.nack = 1'b1;
        end else if (pec_chk_en && byte_is_pec) begin
            dec.src  = SRC_PEC;
            dec.nack = ~pec_ok;
        end else if (!slave_mode) begin
            dec.src  = SRC_MASTER;
            dec.nack = 1'b0;
        end else begin
            dec.src  = SRC_FLAG;
            dec.nack = flag_q;
        end
    end
endmodule

// File: rtl/ack_slot_reg.sv
// Module: holds the acknowledge level for one slot.
// Does: loads the decision on slot_start, keeps it otherwise.
// Assumes: the bit engine drives SDA from nack_q during the whole slot.
module ack_slot_reg
    import ack_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     periph_en,
    input  logic     slot_start,
    input  ack_dec_t dec,
    output logic     nack_q
);
    // Slot register: capture at slot start, return to ACK when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nack_q <= 1'b0;
        else if (!periph_en)
            nack_q <= 1'b0;
        else if (slot_start)
            nack_q <= dec.nack;
    end
endmodule

// File: rtl/slave_ack_ctrl.sv
// Module: top of the slave receive acknowledge controller.
// Does: ties the request flag, overrun memory, decision and slot register.
// Assumes: all inputs synchronous to clk; strobes one cycle wide.
module slave_ack_ctrl
    import ack_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int FLAG_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             slave_mode,
    input  logic             no_stretch,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             nack_sent,
    input  logic             stop_det,
    input  logic             addr_match,
    input  logic             rx_overrun,
    input  logic             pec_chk_en,
    input  logic             byte_is_pec,
    input  logic             pec_ok,
    input  logic             slot_start,
    output logic             nack_out,
    output logic             nack_req_q
);
    logic     flag_q;
    logic     force_ovr;
    ack_dec_t dec;

    nack_req_flag #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_flag (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .nack_sent(nack_sent), .stop_det(stop_det), .addr_match(addr_match),
        .flag_q(flag_q)
    );

    ovr_pending u_ovr (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
        .slave_mode(slave_mode), .no_stretch(no_stretch),
        .rx_overrun(rx_overrun), .slot_start(slot_start), .stop_det(stop_det),
        .force_now(force_ovr)
    );

    ack_select u_sel (
        .force_ovr(force_ovr), .pec_chk_en(pec_chk_en),
        .byte_is_pec(byte_is_pec), .pec_ok(pec_ok),
        .slave_mode(slave_mode), .flag_q(flag_q), .dec(dec)
    );

    ack_slot_reg u_slot (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
        .slot_start(slot_start), .dec(dec), .nack_q(nack_out)
    );

    // Readback is the flag itself.
    always_comb nack_req_q = flag_q;
endmodule

// File: rtl/slave_ack_ctrl_chk.sv
// Checker: temporal properties of slave_ack_ctrl, bound to every instance.
module slave_ack_ctrl_chk #(
    parameter int REG_W    = 16,
    parameter int FLAG_BIT = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             periph_en,
    input logic             slave_mode,
    input logic             no_stretch,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             nack_sent,
    input logic             stop_det,
    input logic             addr_match,
    input logic             rx_overrun,
    input logic             pec_chk_en,
    input logic             byte_is_pec,
    input logic             pec_ok,
    input logic             slot_start,
    input logic             nack_out,
    input logic             nack_req_q
);
    logic clr_any;
    always_comb clr_any = nack_sent | stop_det | addr_match;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && reg_wr && reg_wdata[FLAG_BIT] && !clr_any |=> nack_req_q); // R1
    AST_ZERO_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && reg_wr && !reg_wdata[FLAG_BIT] && !clr_any |=> $stable(nack_req_q)); // R2
    AST_EVENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> !nack_req_q); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> !nack_req_q && !nack_out); // R4
    AST_OVR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && slot_start && slave_mode && no_stretch && rx_overrun |=> nack_out); // R6
    AST_PEC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && slot_start && pec_chk_en && byte_is_pec && !(slave_mode && no_stretch)
        |=> nack_out == !$past(pec_ok)); // R7
    AST_MASTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && slot_start && !slave_mode && !(pec_chk_en && byte_is_pec) |=> !nack_out); // R8
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en && !slot_start |=> $stable(nack_out)); // R9
endmodule

bind slave_ack_ctrl slave_ack_ctrl_chk #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_chk (.*);

// File: tb/tb_slave_ack_ctrl.sv
module tb_slave_ack_ctrl;
    localparam int REG_W = 16;
    localparam int FB    = 15;

    logic clk = 1'b0;
    logic rst_n;
    logic periph_en, slave_mode, no_stretch, reg_wr;
    logic [REG_W-1:0] reg_wdata;
    logic nack_sent, stop_det, addr_match, rx_overrun;
    logic pec_chk_en, byte_is_pec, pec_ok, slot_start;
    logic nack_out, nack_req_q;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    slave_ack_ctrl #(.REG_W(REG_W), .FLAG_BIT(FB)) dut (.*);

    task automatic chk(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_wdata = '0; nack_sent = 0; stop_det = 0;
        addr_match = 0; rx_overrun = 0; slot_start = 0;
    endtask

    // One cycle: inputs already set at negedge, pass a posedge, clear strobes.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic wr_flag(logic v);
        reg_wr = 1; reg_wdata = '0; reg_wdata[FB] = v; step();
    endtask

    task automatic slot();
        slot_start = 1; step();
    endtask

    task automatic t_reset();
        chk("R10", nack_out, 1'b0, "nack_out after reset");
        chk("R10", nack_req_q, 1'b0, "flag after reset");
    endtask

    task automatic t_set_and_zero();
        wr_flag(1'b1);
        chk("R1", nack_req_q, 1'b1, "flag after write 1");
        reg_wr = 1; reg_wdata = 16'h7FFF; step();
        chk("R2", nack_req_q, 1'b1, "flag after write 0 (other bits 1)");
    endtask

    task automatic t_clear_events();
        wr_flag(1'b1); nack_sent = 1; step();
        chk("R3", nack_req_q, 1'b0, "clear by nack_sent");
        wr_flag(1'b1); stop_det = 1; step();
        chk("R3", nack_req_q, 1'b0, "clear by stop");
        wr_flag(1'b1); addr_match = 1; step();
        chk("R3", nack_req_q, 1'b0, "clear by addr match");
        addr_match = 1; reg_wr = 1; reg_wdata = '0; reg_wdata[FB] = 1; step();
        chk("R3", nack_req_q, 1'b0, "clear beats same-cycle set");
        wr_flag(1'b0);
        chk("R2", nack_req_q, 1'b0, "write 0 keeps flag clear");
    endtask

    task automatic t_disable();
        wr_flag(1'b1); slot();
        chk("R5", nack_out, 1'b1, "slot with flag 1");
        periph_en = 0; step();
        chk("R4", nack_req_q, 1'b0, "disable clears flag");
        chk("R9", nack_out, 1'b0, "disable resets nack_out");
        wr_flag(1'b1);
        chk("R4", nack_req_q, 1'b0, "write ignored while disabled");
        periph_en = 1; step();
    endtask

    task automatic t_flag_slots_hold();
        slot();
        chk("R5", nack_out, 1'b0, "slot with flag 0 gives ACK");
        wr_flag(1'b1);
        chk("R9", nack_out, 1'b0, "flag change mid-slot does not move output");
        step();
        chk("R9", nack_out, 1'b0, "still held before next slot");
        slot();
        chk("R5", nack_out, 1'b1, "next slot takes flag 1");
        nack_sent = 1; step();
        chk("R9", nack_out, 1'b1, "held after flag cleared");
    endtask

    task automatic t_overrun();
        no_stretch = 1;
        rx_overrun = 1; slot_start = 1; step();
        chk("R6", nack_out, 1'b1, "overrun with slot same cycle");
        rx_overrun = 1; step(); step();
        slot();
        chk("R6", nack_out, 1'b1, "pending overrun forces NACK");
        slot();
        chk("R6", nack_out, 1'b0, "overrun consumed by slot");
        rx_overrun = 1; step(); stop_det = 1; step(); slot();
        chk("R6", nack_out, 1'b0, "STOP drops pending overrun");
        no_stretch = 0; rx_overrun = 1; slot_start = 1; step();
        chk("R6", nack_out, 1'b0, "overrun ignored when stretching on");
        no_stretch = 1; pec_chk_en = 1; byte_is_pec = 1; pec_ok = 1;
        rx_overrun = 1; slot_start = 1; step();
        chk("R7", nack_out, 1'b1, "overrun beats PEC pass");
        no_stretch = 0;
    endtask

    task automatic t_pec();
        pec_chk_en = 1; byte_is_pec = 1;
        wr_flag(1'b1); pec_ok = 1; slot();
        chk("R7", nack_out, 1'b0, "PEC pass ACK despite flag 1");
        stop_det = 1; step(); pec_ok = 0; slot();
        chk("R7", nack_out, 1'b1, "PEC fail NACK despite flag 0");
        byte_is_pec = 0; slot();
        chk("R7", nack_out, 1'b0, "data byte back to flag");
        pec_chk_en = 0; byte_is_pec = 1; slot();
        chk("R7", nack_out, 1'b0, "check disabled uses flag");
        byte_is_pec = 0;
    endtask

    task automatic t_master();
        slave_mode = 0; wr_flag(1'b1); slot();
        chk("R8", nack_out, 1'b0, "master ignores flag");
        pec_chk_en = 1; byte_is_pec = 1; pec_ok = 0; slot();
        chk("R8", nack_out, 1'b1, "master PEC fail still NACK");
        pec_chk_en = 0; byte_is_pec = 0; slave_mode = 1; slot();
        chk("R5", nack_out, 1'b1, "slave again uses flag");
    endtask

    initial begin
        idle();
        rst_n = 0; periph_en = 1; slave_mode = 1; no_stretch = 0;
        pec_chk_en = 0; byte_is_pec = 0; pec_ok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_set_and_zero();
        t_clear_events();
        t_disable();
        t_flag_slots_hold();
        t_overrun();
        t_pec();
        t_master();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule